// File: doc/BRIEF.md
# Edge/Center-Aligned PWM Timer

This block is a 16-bit counter driving up to four compare channels whose outputs are PWM reference waveforms. Two counting schemes are offered. In edge-aligned mode the counter ramps up and wraps to zero. In center-aligned mode it ramps up and then back down. For equal output frequency, center-aligned mode must therefore be clocked at twice the rate.

Each channel drives its reference high while the counter is below the channel's compare value. Both ends of the duty range are reachable: a compare value of zero gives a constantly low output, and a value at full scale gives a constantly high output. Full scale is the reload value plus one in edge-aligned mode and the reload value itself in center-aligned mode.

The reload value and the compare values are written into preload registers. They are copied into the active registers only at an update event, which happens once per period. Software can therefore change the period and duties at any time without producing a malformed cycle. A count enable pauses the counter. A synchronous reset restarts the count and forces the preloaded values active at once.

Top module: `pwm_timer`

## Requirements
- R1: With center_mode_i low and counting enabled, with active reload value A, cnt_o steps 0, 1, ..., A and then returns to 0. The period is A+1 cycles, and A = 0 holds the count at 0.
- R2: In edge-aligned mode, pwm_o[k] is 1 exactly while cnt_o is below the active compare value C of channel k. Each period therefore holds min(C, A+1) high cycles: C = 0 never goes high, and C >= A+1 stays high.
- R3: With center_mode_i high and A >= 1, cnt_o steps 0 to A-1 with down_o = 0, then A down to 1 with down_o = 1, then returns to 0. The period is 2A cycles.
- R4: In center-aligned mode, pwm_o[k] is 1 while cnt_o < C when down_o = 0, and while cnt_o <= C when down_o = 1. Each period holds 2*min(C, A) high cycles: C = 0 never goes high, and C >= A stays high.
- R5: Writes to the reload preload (arr_we_i) and to the compare preload of channel k (cmp_we_i[k], data from cmp_wdata_i) leave the count and the outputs unchanged until the next update event. A write presented in the same cycle as the update event takes effect in that update.
- R6: The update event happens on the transition into count 0 that ends a period (the wrap in edge-aligned mode, the descent from 1 in center-aligned mode). upd_o is high for exactly the cycle in which cnt_o first shows that 0, and at no other time.
- R7: While en_i is low, cnt_o and down_o hold their values, pwm_o does not change, and upd_o stays low.
- R8: When rst_i is sampled high, the next cycle shows cnt_o = 0, down_o = 0 and upd_o = 0. The active registers are loaded from the preloads, including a write made in that same cycle. The preloads keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| center_mode_i | input | 1 | 1 = center-aligned up/down counting, 0 = edge-aligned |
| arr_we_i | input | 1 | Write strobe for the reload preload |
| arr_wdata_i | input | CNT_W | Reload preload data |
| cmp_we_i | input | NCH | Per-channel write strobe for the compare preload |
| cmp_wdata_i | input | CNT_W+1 | Compare preload data, shared by all channels |
| cnt_o | output | CNT_W | Current count |
| down_o | output | 1 | 1 while in the descending half of a center-aligned period |
| upd_o | output | 1 | One-cycle pulse marking the first cycle of a new period |
| pwm_o | output | NCH | PWM reference of each channel, bit k = channel k |

## Verification
The assertions assume that the active reload value is at least 1 whenever center-aligned mode is selected. They also assume that center_mode_i changes only while the block is in reset. Under those conditions the count never exceeds the reload value, and each single-step rule holds. The bench switches mode and writes its zero reload value only with rst_i held high, and it restarts from reset after every mode change. Mid-run writes to the preloads come at arbitrary phases, including the exact update cycle, because the assertions place no constraint on them.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int unsigned DEF_CNT_W = 16;
    localparam int unsigned DEF_NCH   = 4;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             center_mode_i,
    input  logic [CNT_W-1:0] arr_act_i,
    output logic [CNT_W-1:0] cnt_o,
    output cnt_dir_e         dir_o,
    output logic             upd_evt_o,
    output logic             upd_o
);

    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
        logic             upd;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       evt_d;
    logic [EXT_W-1:0] cnt_plus1;

    always_comb begin
        state_d   = state_q;
        state_d.upd = 1'b0;
        evt_d     = 1'b0;
        cnt_plus1 = {1'b0, state_q.cnt} + EXT_W'(1);
        if (rst_i) begin
            state_d.cnt = '0;
            state_d.dir = DIR_UP;
        end else if (en_i) begin
            if (!center_mode_i) begin
                // edge-aligned: ramp up, wrap after the reload value
                state_d.dir = DIR_UP;
                if (state_q.cnt >= arr_act_i) begin
                    state_d.cnt = '0;
                    evt_d       = 1'b1;
                end else begin
                    state_d.cnt = cnt_plus1[CNT_W-1:0];
                end
            end else if (state_q.dir == DIR_UP) begin
                // center-aligned ascending half ends when the peak is reached
                if (cnt_plus1 >= {1'b0, arr_act_i}) begin
                    state_d.cnt = arr_act_i;
                    state_d.dir = DIR_DOWN;
                end else begin
                    state_d.cnt = cnt_plus1[CNT_W-1:0];
                end
            end else begin
                // descending half ends on the step into zero
                if (state_q.cnt <= CNT_W'(1)) begin
                    state_d.cnt = '0;
                    state_d.dir = DIR_UP;
                    evt_d       = 1'b1;
                end else begin
                    state_d.cnt = state_q.cnt - CNT_W'(1);
                end
            end
            state_d.upd = evt_d;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign cnt_o     = state_q.cnt;
    assign dir_o     = state_q.dir;
    assign upd_o     = state_q.upd;
    assign upd_evt_o = evt_d;

endmodule

// File: rtl/pwm_timer_shadow.sv
module pwm_timer_shadow
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned NCH   = DEF_NCH
) (
    input  logic                      clk_i,
    input  logic                      load_i,
    input  logic                      arr_we_i,
    input  logic [CNT_W-1:0]          arr_wdata_i,
    input  logic [NCH-1:0]            cmp_we_i,
    input  logic [CNT_W:0]            cmp_wdata_i,
    output logic [CNT_W-1:0]          arr_act_o,
    output logic [NCH-1:0][CNT_W:0]   cmp_act_o
);

    localparam int unsigned CMP_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]          arr_pre;
        logic [CNT_W-1:0]          arr_act;
        logic [NCH-1:0][CMP_W-1:0] cmp_pre;
        logic [NCH-1:0][CMP_W-1:0] cmp_act;
    } shadow_t;

    shadow_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (arr_we_i) begin
            regs_d.arr_pre = arr_wdata_i;
        end
        for (int k = 0; k < NCH; k++) begin
            if (cmp_we_i[k]) begin
                regs_d.cmp_pre[k] = cmp_wdata_i;
            end
        end
        // transfer sees a write made in the same cycle
        if (load_i) begin
            regs_d.arr_act = regs_d.arr_pre;
            regs_d.cmp_act = regs_d.cmp_pre;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign arr_act_o = regs_q.arr_act;
    assign cmp_act_o = regs_q.cmp_act;

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  cnt_dir_e         dir_i,
    input  logic [CNT_W:0]   cmp_i,
    output logic             ref_o
);

    logic [CNT_W:0] cnt_ext;

    always_comb begin
        cnt_ext = {1'b0, cnt_i};
        // descending half uses an inclusive test so duty stays linear in C
        if (dir_i == DIR_DOWN) begin
            ref_o = (cnt_ext <= cmp_i);
        end else begin
            ref_o = (cnt_ext < cmp_i);
        end
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned NCH   = DEF_NCH
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             center_mode_i,
    input  logic             arr_we_i,
    input  logic [CNT_W-1:0] arr_wdata_i,
    input  logic [NCH-1:0]   cmp_we_i,
    input  logic [CNT_W:0]   cmp_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             upd_o,
    output logic [NCH-1:0]   pwm_o
);

    localparam int unsigned CMP_W = CNT_W + 1;

    logic [CNT_W-1:0]          arr_act;
    logic [NCH-1:0][CMP_W-1:0] cmp_act;
    cnt_dir_e                  dir;
    logic                      upd_evt;
    logic                      load;

    assign load   = rst_i | upd_evt;
    assign down_o = (dir == DIR_DOWN);

    pwm_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .en_i          (en_i),
        .center_mode_i (center_mode_i),
        .arr_act_i     (arr_act),
        .cnt_o         (cnt_o),
        .dir_o         (dir),
        .upd_evt_o     (upd_evt),
        .upd_o         (upd_o)
    );

    pwm_timer_shadow #(.CNT_W(CNT_W), .NCH(NCH)) u_shadow (
        .clk_i       (clk_i),
        .load_i      (load),
        .arr_we_i    (arr_we_i),
        .arr_wdata_i (arr_wdata_i),
        .cmp_we_i    (cmp_we_i),
        .cmp_wdata_i (cmp_wdata_i),
        .arr_act_o   (arr_act),
        .cmp_act_o   (cmp_act)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pwm_timer_channel #(.CNT_W(CNT_W)) u_ch (
            .cnt_i (cnt_o),
            .dir_i (dir),
            .cmp_i (cmp_act[k]),
            .ref_o (pwm_o[k])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NCH   = 4
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     en_i,
    input logic                     center_mode_i,
    input logic [CNT_W-1:0]         cnt_o,
    input logic                     down_o,
    input logic                     upd_o,
    input logic [NCH-1:0]           pwm_o,
    input logic [CNT_W-1:0]         arr_act,
    input logic [NCH-1:0][CNT_W:0]  cmp_act
);

    AST_RST_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == '0 && !down_o && !upd_o)); // R8

    AST_EDGE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !center_mode_i && cnt_o < arr_act)
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R1

    AST_EDGE_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !center_mode_i && cnt_o >= arr_act)
        |=> (cnt_o == '0 && upd_o)); // R1

    AST_CENTER_PEAK: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && center_mode_i && !down_o && ({1'b0, cnt_o} + 1'b1 == {1'b0, arr_act}))
        |=> (down_o && cnt_o == $past(arr_act))); // R3

    AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(cnt_o) && $stable(down_o) && !upd_o)); // R7

    AST_UPD_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |-> (cnt_o == '0 && !down_o)); // R6

    AST_SHADOW_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!upd_o && !$past(rst_i)) |-> ($stable(arr_act) && $stable(cmp_act))); // R5

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (rst_i)
            (cmp_act[k] == '0) |-> !pwm_o[k]); // R2
    end

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .en_i          (en_i),
    .center_mode_i (center_mode_i),
    .cnt_o         (cnt_o),
    .down_o        (down_o),
    .upd_o         (upd_o),
    .pwm_o         (pwm_o),
    .arr_act       (arr_act),
    .cmp_act       (cmp_act)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;

    localparam int CNT_W = 16;
    localparam int NCH   = 4;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             en_i = 1'b0;
    logic             center_mode_i = 1'b0;
    logic             arr_we_i = 1'b0;
    logic [CNT_W-1:0] arr_wdata_i = '0;
    logic [NCH-1:0]   cmp_we_i = '0;
    logic [CNT_W:0]   cmp_wdata_i = '0;
    logic [CNT_W-1:0] cnt_o;
    logic             down_o;
    logic             upd_o;
    logic [NCH-1:0]   pwm_o;

    int n_checks = 0;
    int n_errors = 0;
    int duty [NCH];

    pwm_timer #(.CNT_W(CNT_W), .NCH(NCH)) u_dut (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .center_mode_i(center_mode_i),
        .arr_we_i(arr_we_i), .arr_wdata_i(arr_wdata_i),
        .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
        .cnt_o(cnt_o), .down_o(down_o), .upd_o(upd_o), .pwm_o(pwm_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_i);
    endtask

    task automatic write_arr(input int v);
        arr_we_i = 1'b1; arr_wdata_i = CNT_W'(v);
        step();
        arr_we_i = 1'b0;
    endtask

    task automatic write_cmp(input int k, input int v);
        cmp_we_i = '0; cmp_we_i[k] = 1'b1; cmp_wdata_i = (CNT_W+1)'(v);
        step();
        cmp_we_i = '0;
    endtask

    task automatic clear_duty();
        for (int k = 0; k < NCH; k++) duty[k] = 0;
    endtask

    task automatic add_duty();
        for (int k = 0; k < NCH; k++) if (pwm_o[k]) duty[k]++;
    endtask

    // reset with configuration loaded while reset is held
    task automatic configure(input bit center, input int arr, input int c0, input int c1,
                             input int c2, input int c3);
        rst_i = 1'b1; en_i = 1'b0; center_mode_i = center;
        write_arr(arr);
        write_cmp(0, c0); write_cmp(1, c1); write_cmp(2, c2); write_cmp(3, c3);
        step();
    endtask

    task automatic t_reset();
        configure(1'b0, 4, 0, 2, 5, 3);
        check("R8", "cnt in reset", int'(cnt_o), 0);
        check("R8", "down in reset", int'(down_o), 0);
        check("R8", "upd in reset", int'(upd_o), 0);
        check("R8", "pwm in reset", int'(pwm_o), 4'b1110);
        rst_i = 1'b0; en_i = 1'b1;
    endtask

    task automatic t_edge();
        clear_duty();
        for (int i = 0; i < 10; i++) begin
            check("R1", "edge count", int'(cnt_o), i % 5);
            check("R6", "edge upd", int'(upd_o), (i % 5 == 0 && i > 0) ? 1 : 0);
            check("R1", "edge down", int'(down_o), 0);
            if (i < 5) add_duty();
            step();
        end
        check("R2", "edge duty C=0", duty[0], 0);
        check("R2", "edge duty C=2", duty[1], 2);
        check("R2", "edge duty C=A+1", duty[2], 5);
        check("R2", "edge duty C=3", duty[3], 3);
    endtask

    task automatic t_preload();
        step();                 // cnt = 1
        write_cmp(1, 4);        // cnt = 2
        write_arr(2);           // cnt = 3
        check("R5", "cnt before update", int'(cnt_o), 3);
        check("R5", "old compare still used", int'(pwm_o[1]), 0);
        step();
        check("R5", "old reload still used", int'(cnt_o), 4);
        step();
        check("R6", "upd at new period", int'(upd_o), 1);
        clear_duty();
        for (int i = 0; i < 6; i++) begin
            check("R5", "new period count", int'(cnt_o), i % 3);
            if (i < 3) add_duty();
            step();
        end
        check("R5", "new duty ch1", duty[1], 3);
        check("R2", "new duty ch0", duty[0], 0);
        check("R2", "new duty ch3 full", duty[3], 3);
    endtask

    task automatic t_enable();
        en_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R7", "held count", int'(cnt_o), 0);
            check("R7", "no upd while paused", int'(upd_o), 0);
            check("R7", "pwm while paused", int'(pwm_o), 4'b1110);
        end
        en_i = 1'b1;
    endtask

    task automatic t_reset_load();
        rst_i = 1'b1; cmp_we_i = 4'b0001; cmp_wdata_i = 17'd2;
        step();
        rst_i = 1'b0; cmp_we_i = '0;
        check("R8", "cnt after sync reset", int'(cnt_o), 0);
        check("R8", "same-cycle write active", int'(pwm_o[0]), 1);
        step();
        check("R8", "count 1", int'(cnt_o), 1);
        check("R8", "ch0 at 1", int'(pwm_o[0]), 1);
        step();
        check("R8", "count 2", int'(cnt_o), 2);
        check("R8", "ch0 at 2", int'(pwm_o[0]), 0);
        step();
        check("R8", "reload preload kept", int'(cnt_o), 0);
    endtask

    task automatic t_center();
        int pos;
        configure(1'b1, 4, 0, 2, 4, 3);
        rst_i = 1'b0; en_i = 1'b1;
        clear_duty();
        for (int i = 0; i < 16; i++) begin
            pos = i % 8;
            check("R3", "center count", int'(cnt_o), (pos <= 4) ? pos : 8 - pos);
            check("R3", "center down", int'(down_o), (pos >= 4) ? 1 : 0);
            check("R6", "center upd", int'(upd_o), (pos == 0 && i > 0) ? 1 : 0);
            if (i < 8) add_duty();
            step();
        end
        check("R4", "center duty C=0", duty[0], 0);
        check("R4", "center duty C=2", duty[1], 4);
        check("R4", "center duty C=A", duty[2], 8);
        check("R4", "center duty C=3", duty[3], 6);
        for (int i = 0; i < 7; i++) step();
        check("R3", "last descent step", int'(cnt_o), 1);
        write_cmp(1, 1);       // lands on the update edge
        check("R6", "upd after turnaround", int'(upd_o), 1);
        clear_duty();
        for (int i = 0; i < 8; i++) begin
            add_duty();
            step();
        end
        check("R5", "write on update cycle", duty[1], 2);
    endtask

    task automatic t_edge_zero();
        configure(1'b0, 0, 0, 1, 0, 1);
        rst_i = 1'b0; en_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R1", "A=0 count", int'(cnt_o), 0);
            check("R6", "A=0 upd every cycle", int'(upd_o), 1);
            check("R2", "A=0 pwm", int'(pwm_o), 4'b1010);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_edge();
        t_preload();
        t_enable();
        t_reset_load();
        t_center();
        t_edge_zero();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule